// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core between four power states: full power, doze, nap and sleep. Software asks for a state by presenting a mode code with a one-cycle write strobe. The controller then drives one clock-enable per functional-unit group (snoop, data cache, decrementer) and reports the state actually in effect. In full power the enables either stay on, or, with dynamic power management selected, follow a per-unit demand vector from instruction dispatch.

Doze takes effect on the write alone. Nap and sleep first raise a quiesce request to the peripheral logic. The controller holds full-power behaviour until that logic returns a quiesce acknowledge. Each low-power state has its own set of wake events, and every wake leads back to full power only. A software request made outside full power is dropped. A hard reset (active-low) or a soft reset (active-high) forces full power asynchronously.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low or `soft_rst` is high, the block is forced at once into full power: `mode_stat` = 0, `qreq` = 0, and any pending nap or sleep request is cleared.
- R2: In full power, and while a nap or sleep request waits for its acknowledge, `unit_en` is 3'b111 when `dpm_en` = 0 and equals `unit_demand` when `dpm_en` = 1. The enable bits are: bit 0 snoop, bit 1 data cache, bit 2 decrementer.
- R3: In full power with no wake event, a write with `req_mode` = 1 enters doze on the next clock edge (`mode_stat` = 1). In doze, `unit_en` = {1, `unit_demand[1]`, 1}.
- R4: In full power with no wake event, a write with `req_mode` = 2 (nap) or 3 (sleep) raises `qreq` after the next edge while `mode_stat` stays 0. The first edge that samples `qack` high moves `mode_stat` to 2 or 3.
- R5: In nap, `unit_en` = 3'b100. In sleep, `unit_en` = 3'b000. `qreq` stays high in both.
- R6: In doze or nap, any of `irq`, `smi`, `dec_evt` or `mcp` returns the block to full power on the next edge.
- R7: In sleep, `irq`, `smi` or `mcp` returns the block to full power on the next edge. `dec_evt` alone leaves it in sleep.
- R8: In nap or sleep, `qack` sampled low returns the block to full power on the next edge and drops `qreq`.
- R9: A write made in any state other than full power, including while an acknowledge is awaited, is dropped and does not change `mode_stat`. A write with `req_mode` = 0 has no effect.
- R10: A wake event (`irq`, `smi`, `dec_evt`, `mcp`) sampled together with a write in full power, or while an acknowledge is awaited, abandons the request. The block stays in full power with `qreq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, asynchronous, active high |
| req_valid | input | 1 | Software mode write strobe |
| req_mode | input | 2 | Requested mode: 0 full, 1 doze, 2 nap, 3 sleep |
| qack | input | 1 | Quiesce acknowledge from peripheral logic |
| irq | input | 1 | External interrupt |
| smi | input | 1 | System management interrupt |
| dec_evt | input | 1 | Decrementer exception |
| mcp | input | 1 | Machine check |
| dpm_en | input | 1 | Dynamic power management select for full power |
| unit_demand | input | 3 | Per-unit demand from dispatch (bit 0 snoop, 1 dcache, 2 decrementer) |
| unit_en | output | 3 | Per-unit clock enable |
| qreq | output | 1 | Quiesce request to peripheral logic |
| mode_stat | output | 2 | Mode in effect: 0 full, 1 doze, 2 nap, 3 sleep |

## Verification
A mode write and a wake event can land on the same clock edge. A wake event can also land on the very edge where the acknowledge arrives for a pending nap or sleep. In both cases the wake has to win and the block must stay in full power. Directed steps raise `smi` or `mcp` in the cycle of the write, and again while the request is pending. The random phase keeps `qack` toggling slowly while strobes and wake events fire at independent rates, so both collisions recur many times. Each edge is judged against a bench-side state model that applies the wake-first rule.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int unsigned UNIT_COUNT  = 3;
  localparam int unsigned UNIT_SNOOP  = 0;
  localparam int unsigned UNIT_DCACHE = 1;
  localparam int unsigned UNIT_DEC    = 2;
  localparam int unsigned MODE_W      = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_FULL  = 2'd0,
    MODE_DOZE  = 2'd1,
    MODE_NAP   = 2'd2,
    MODE_SLEEP = 2'd3
  } pm_mode_e;

  typedef enum logic [2:0] {
    ST_FULL       = 3'd0,
    ST_DOZE       = 3'd1,
    ST_NAP_WAIT   = 3'd2,
    ST_SLEEP_WAIT = 3'd3,
    ST_NAP        = 3'd4,
    ST_SLEEP      = 3'd5
  } pm_state_e;

  typedef struct packed {
    logic ack_lost;
    logic mcheck;
    logic decr;
    logic smint;
    logic extint;
  } wake_vec_t;

  // Which wake sources count in each state.
  function automatic wake_vec_t wake_mask(pm_state_e st);
    wake_vec_t m;
    m = '{ack_lost: 1'b0, mcheck: 1'b1, decr: 1'b1, smint: 1'b1, extint: 1'b1};
    case (st)
      ST_NAP:   m.ack_lost = 1'b1;
      ST_SLEEP: begin
        m.ack_lost = 1'b1;
        m.decr     = 1'b0;
      end
      default: ;
    endcase
    return m;
  endfunction

  function automatic pm_state_e entry_state(pm_mode_e md);
    case (md)
      MODE_DOZE:  return ST_DOZE;
      MODE_NAP:   return ST_NAP_WAIT;
      MODE_SLEEP: return ST_SLEEP_WAIT;
      default:    return ST_FULL;
    endcase
  endfunction

  function automatic pm_mode_e state_mode(pm_state_e st);
    case (st)
      ST_DOZE:  return MODE_DOZE;
      ST_NAP:   return MODE_NAP;
      ST_SLEEP: return MODE_SLEEP;
      default:  return MODE_FULL;
    endcase
  endfunction

  function automatic logic holds_quiesce(pm_state_e st);
    return (st == ST_NAP_WAIT) || (st == ST_SLEEP_WAIT) ||
           (st == ST_NAP) || (st == ST_SLEEP);
  endfunction

  function automatic logic unit_clocked(pm_state_e st, int unsigned u,
                                        logic dpm, logic dem);
    case (st)
      ST_FULL, ST_NAP_WAIT, ST_SLEEP_WAIT: return dpm ? dem : 1'b1;
      ST_DOZE:  return (u == UNIT_DCACHE) ? dem : 1'b1;
      ST_NAP:   return (u == UNIT_DEC);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval
  import pwr_mode_pkg::*;
(
  input  pm_state_e state,
  input  logic      irq,
  input  logic      smi,
  input  logic      dec_evt,
  input  logic      mcp,
  input  logic      qack,
  output logic      wake_hit
);

  wake_vec_t raw;
  wake_vec_t live;

  always_comb begin
    raw.ack_lost = ~qack;
    raw.mcheck   = mcp;
    raw.decr     = dec_evt;
    raw.smint    = smi;
    raw.extint   = irq;
    live         = raw & wake_mask(state);
  end

  assign wake_hit = |live;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              qack,
  input  logic              wake_hit,
  output pm_state_e         state,
  output logic              req_accept
);

  pm_state_e nxt;

  assign req_accept = (state == ST_FULL) && req_valid && !wake_hit &&
                      (req_mode != MODE_FULL);

  always_comb begin
    nxt = state;
    case (state)
      ST_FULL:
        if (req_accept) nxt = entry_state(pm_mode_e'(req_mode));
      ST_DOZE, ST_NAP, ST_SLEEP:
        if (wake_hit) nxt = ST_FULL;
      ST_NAP_WAIT:
        if (wake_hit)  nxt = ST_FULL;
        else if (qack) nxt = ST_NAP;
      ST_SLEEP_WAIT:
        if (wake_hit)  nxt = ST_FULL;
        else if (qack) nxt = ST_SLEEP;
      default:
        nxt = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state <= ST_FULL;
    else         state <= nxt;
  end

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_mode_pkg::*;
(
  input  pm_state_e             state,
  input  logic                  dpm_en,
  input  logic [UNIT_COUNT-1:0] unit_demand,
  output logic [UNIT_COUNT-1:0] unit_en,
  output logic                  qreq,
  output logic [MODE_W-1:0]     mode_stat
);

  for (genvar u = 0; u < UNIT_COUNT; u++) begin : g_unit
    assign unit_en[u] = unit_clocked(state, u, dpm_en, unit_demand[u]);
  end

  assign qreq      = holds_quiesce(state);
  assign mode_stat = state_mode(state);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  req_valid,
  input  logic [MODE_W-1:0]     req_mode,
  input  logic                  qack,
  input  logic                  irq,
  input  logic                  smi,
  input  logic                  dec_evt,
  input  logic                  mcp,
  input  logic                  dpm_en,
  input  logic [UNIT_COUNT-1:0] unit_demand,
  output logic [UNIT_COUNT-1:0] unit_en,
  output logic                  qreq,
  output logic [MODE_W-1:0]     mode_stat
);

  logic      arst_n;
  logic      wake_hit;
  logic      req_accept;
  pm_state_e state;

  assign arst_n = rst_n & ~soft_rst;

  pwr_wake_eval u_wake (
    .state   (state),
    .irq     (irq),
    .smi     (smi),
    .dec_evt (dec_evt),
    .mcp     (mcp),
    .qack    (qack),
    .wake_hit(wake_hit)
  );

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .arst_n    (arst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .qack      (qack),
    .wake_hit  (wake_hit),
    .state     (state),
    .req_accept(req_accept)
  );

  pwr_clk_gate u_gate (
    .state      (state),
    .dpm_en     (dpm_en),
    .unit_demand(unit_demand),
    .unit_en    (unit_en),
    .qreq       (qreq),
    .mode_stat  (mode_stat)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
(
  input logic                  clk,
  input logic                  arst_n,
  input logic                  req_valid,
  input logic [MODE_W-1:0]     req_mode,
  input logic                  qack,
  input logic                  irq,
  input logic                  smi,
  input logic                  dec_evt,
  input logic                  mcp,
  input logic [UNIT_COUNT-1:0] unit_en,
  input logic                  qreq,
  input logic [MODE_W-1:0]     mode_stat,
  input logic                  wake_hit,
  input logic                  req_accept
);

  always @(posedge clk) begin
    if (!arst_n) begin
      AST_RESET_FULL: assert (mode_stat == MODE_FULL && !qreq); // R1
    end
  end

  AST_DOZE_ENTRY: assert property (@(posedge clk) disable iff (!arst_n)
    req_accept && req_mode == MODE_DOZE |=> mode_stat == MODE_DOZE); // R3

  AST_ACK_GATE: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat == MODE_NAP && $past(mode_stat) != MODE_NAP |-> $past(qack) && $past(qreq)); // R4

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat == MODE_SLEEP |-> unit_en == '0 && qreq); // R5

  AST_NAP_WAKE: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat == MODE_NAP && (irq || smi || dec_evt || mcp) |=> mode_stat == MODE_FULL); // R6

  AST_SLEEP_DEC_IGNORED: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat == MODE_SLEEP && dec_evt && !irq && !smi && !mcp && qack |=> mode_stat == MODE_SLEEP); // R7

  AST_ACK_LOSS_EXIT: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat != MODE_FULL && mode_stat != MODE_DOZE && !qack |=> mode_stat == MODE_FULL && !qreq); // R8

  AST_NO_HOP: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat != MODE_FULL |=> mode_stat == MODE_FULL || $stable(mode_stat)); // R9

  AST_ABANDON: assert property (@(posedge clk) disable iff (!arst_n)
    qreq && mode_stat == MODE_FULL && wake_hit |=> !qreq && mode_stat == MODE_FULL); // R10

  AST_WAKE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!arst_n)
    mode_stat == MODE_FULL && !qreq && req_valid && wake_hit |=> mode_stat == MODE_FULL && !qreq); // R10

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .qack      (qack),
  .irq       (irq),
  .smi       (smi),
  .dec_evt   (dec_evt),
  .mcp       (mcp),
  .unit_en   (unit_en),
  .qreq      (qreq),
  .mode_stat (mode_stat),
  .wake_hit  (wake_hit),
  .req_accept(req_accept)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

  localparam int M_FULL = 0, M_DOZE = 1, M_NWAIT = 2, M_SWAIT = 3, M_NAP = 4, M_SLEEP = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic       qack = 1'b0;
  logic       irq = 1'b0, smi = 1'b0, dec_evt = 1'b0, mcp = 1'b0;
  logic       dpm_en = 1'b0;
  logic [2:0] unit_demand = 3'b000;
  logic [2:0] unit_en;
  logic       qreq;
  logic [1:0] mode_stat;

  int checks = 0;
  int failures = 0;
  int ref_st = M_FULL;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req_valid(req_valid),
    .req_mode(req_mode), .qack(qack), .irq(irq), .smi(smi), .dec_evt(dec_evt),
    .mcp(mcp), .dpm_en(dpm_en), .unit_demand(unit_demand), .unit_en(unit_en),
    .qreq(qreq), .mode_stat(mode_stat)
  );

  function automatic int next_of(int s);
    logic common;
    common = irq | smi | dec_evt | mcp;
    if (!rst_n || soft_rst) return M_FULL;
    case (s)
      M_FULL:
        if (req_valid && !common)
          return (req_mode == 2'd1) ? M_DOZE : (req_mode == 2'd2) ? M_NWAIT :
                 (req_mode == 2'd3) ? M_SWAIT : M_FULL;
        else return M_FULL;
      M_DOZE:  return common ? M_FULL : M_DOZE;
      M_NWAIT: return common ? M_FULL : (qack ? M_NAP : M_NWAIT);
      M_SWAIT: return common ? M_FULL : (qack ? M_SLEEP : M_SWAIT);
      M_NAP:   return (common || !qack) ? M_FULL : M_NAP;
      default: return (irq || smi || mcp || !qack) ? M_FULL : M_SLEEP;
    endcase
  endfunction

  function automatic logic [2:0] exp_en(int s);
    case (s)
      M_DOZE:  return {1'b1, unit_demand[1], 1'b1};
      M_NAP:   return 3'b100;
      M_SLEEP: return 3'b000;
      default: return dpm_en ? unit_demand : 3'b111;
    endcase
  endfunction

  function automatic logic exp_q(int s);
    return (s == M_NWAIT) || (s == M_SWAIT) || (s == M_NAP) || (s == M_SLEEP);
  endfunction

  function automatic logic [1:0] exp_mode(int s);
    return (s == M_DOZE) ? 2'd1 : (s == M_NAP) ? 2'd2 : (s == M_SLEEP) ? 2'd3 : 2'd0;
  endfunction

  task automatic compare(string tag);
    checks += 3;
    if (mode_stat !== exp_mode(ref_st)) begin
      failures++;
      $display("FAIL %s mode_stat act=%0d exp=%0d", tag, mode_stat, exp_mode(ref_st));
    end
    if (qreq !== exp_q(ref_st)) begin
      failures++;
      $display("FAIL %s qreq act=%0b exp=%0b", tag, qreq, exp_q(ref_st));
    end
    if (unit_en !== exp_en(ref_st)) begin
      failures++;
      $display("FAIL %s unit_en act=%b exp=%b", tag, unit_en, exp_en(ref_st));
    end
  endtask

  // Inputs are already set; advance one edge and compare.
  task automatic step(string tag);
    int nxt;
    nxt = next_of(ref_st);
    @(posedge clk);
    #1;
    ref_st = nxt;
    compare(tag);
  endtask

  task automatic idle();
    req_valid = 1'b0; irq = 1'b0; smi = 1'b0; dec_evt = 1'b0; mcp = 1'b0;
  endtask

  function automatic string tag_of(int s);
    case (s)
      M_DOZE:           return "R3";
      M_NWAIT, M_SWAIT: return "R4";
      M_NAP, M_SLEEP:   return "R5";
      default:          return "R2";
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    ref_st = M_FULL;
    compare("R1");
    rst_n = 1'b1;
    step("R1");

    dpm_en = 1'b1; unit_demand = 3'b010; step("R2");
    dpm_en = 1'b0; step("R2");

    req_valid = 1'b1; req_mode = 2'd1; step("R3");
    idle(); unit_demand = 3'b000; step("R3");

    req_valid = 1'b1; req_mode = 2'd2; step("R9");
    idle(); dec_evt = 1'b1; step("R6");
    idle(); req_valid = 1'b1; req_mode = 2'd0; step("R9");

    req_valid = 1'b1; req_mode = 2'd2; qack = 1'b0; step("R4");
    req_valid = 1'b1; req_mode = 2'd1; step("R9");
    idle(); step("R4");
    qack = 1'b1; step("R4");
    step("R5");
    qack = 1'b0; step("R8");

    req_valid = 1'b1; req_mode = 2'd3; step("R4");
    idle(); qack = 1'b1; step("R4");
    dec_evt = 1'b1; step("R7");
    step("R7");
    dec_evt = 1'b0; irq = 1'b1; step("R7");

    idle(); req_valid = 1'b1; req_mode = 2'd2; step("R4");
    idle(); qack = 1'b0; step("R4");
    smi = 1'b1; qack = 1'b1; step("R10");
    idle(); req_valid = 1'b1; req_mode = 2'd3; mcp = 1'b1; step("R10");

    idle(); req_valid = 1'b1; req_mode = 2'd3; step("R4");
    idle(); step("R5");
    soft_rst = 1'b1; step("R1");
    soft_rst = 1'b0; step("R1");

    req_valid = 1'b1; req_mode = 2'd2; step("R4");
    idle(); step("R5");
    mcp = 1'b1; step("R6");
    idle(); req_valid = 1'b1; req_mode = 2'd3; step("R4");
    idle(); step("R5");
    qack = 1'b0; step("R8");

    for (int i = 0; i < 4000; i++) begin
      req_valid   = ($urandom_range(3) == 0);
      req_mode    = 2'($urandom_range(3));
      if ($urandom_range(7) == 0) qack = ~qack;
      irq         = ($urandom_range(19) == 0);
      smi         = ($urandom_range(39) == 0);
      dec_evt     = ($urandom_range(14) == 0);
      mcp         = ($urandom_range(59) == 0);
      soft_rst    = ($urandom_range(199) == 0);
      dpm_en      = 1'($urandom_range(1));
      unit_demand = 3'($urandom_range(7));
      step(tag_of(ref_st));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule